// File: doc/BRIEF.md
# Amplifier Protection Fault Supervisor

This block decides the protection state of a four-channel bridged power amplifier. It reads a digitized supply-voltage code at 0.1 V per LSB and a digitized die-temperature code at 1 °C per LSB. It also reads one over-current flag per channel and two flags that report a sagging gate-drive charge pump and a sagging internal 5 V regulator. From these inputs it drives four registered commands:

- a fault flag;
- a mute request for the audio path;
- a sleep request for supply surges (load dump);
- a command that tri-states every bridge output.

Supply and temperature faults use hysteretic comparators. Each one trips at one code and releases only at a separate code on the far side of a dead band. Over-current faults go to a latch that clears itself. The latch is timed by a 1 kHz tick input and releases a fixed number of ticks after the last flagged cycle. Each fault class maps to its own action. Supply and temperature faults mute. A supply surge requests sleep. Every fault raises the fault flag and tri-states the outputs.

Top module: `prot_fault_supervisor`

## Requirements
- R1: After a synchronous reset all four outputs are low and the over-current latch is idle, as long as the voltage code stays between the under- and over-voltage trip codes and no flag is raised.
- R2: The over-voltage fault sets when the voltage code exceeds 300 (30.0 V). While it is set it holds for every code of 280 or more. It clears once the code drops below 280 (28.0 V). While set it raises fault, mute and tri-state.
- R3: The under-voltage fault sets when the voltage code is below 81 (8.1 V). It holds up to and including code 95. It clears once the code exceeds 95 (9.5 V). While set it raises fault, mute and tri-state.
- R4: The over-temperature fault sets when the temperature code exceeds 160. It holds down to and including 130. It clears once the code drops below 130. While set it raises fault, mute and tri-state.
- R5: The sleep request is high exactly while the voltage code exceeds 300. It has no hysteresis, so at code 290 it is low even while the over-voltage mute is still held.
- R6: A high level on any of the four over-current flags sets the over-current latch. That raises fault and tri-state but not mute. Once all flags are low, the latch clears on the 600th tick.
- R7: A flagged cycle while the latch is already set restarts the count, so a full 600 ticks counted from the newest flagged cycle are needed to clear it.
- R8: The charge-pump-low and regulator-low flags each raise fault and tri-state while high, without mute or sleep.
- R9: Tri-state always equals the fault flag. Mute is raised only by over-voltage, under-voltage or over-temperature.
- R10: Each output reflects an input change made before clock edge k at edge k+1 and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle pulse at 1 kHz, time base of the over-current latch |
| vsup_code_i | input | 10 | Supply voltage code, 0.1 V per LSB |
| temp_code_i | input | 8 | Die temperature code, 1 °C per LSB |
| oc_flag_i | input | 4 | Per-channel over-current level flags |
| cp_low_i | input | 1 | Charge pump voltage low |
| reg_low_i | input | 1 | 5 V regulator voltage low |
| fault_o | output | 1 | Any protection condition present |
| mute_req_o | output | 1 | Mute request from supply or temperature faults |
| sleep_req_o | output | 1 | Load-dump sleep request |
| tristate_o | output | 1 | Tri-state command for all bridge outputs |

## Verification
The hardest case to reach is the restart of the over-current timer. The latch must be half-way through its 600-tick hold, with no flag present, when a new single-cycle flag arrives. The bench drives the tick input itself from a task, so it knows the exact tick count. It re-raises a flag after 300 ticks and then shows that the fault survives 599 further ticks and clears on the 600th. The hysteresis bands are reached by walking the codes up through each trip code and back down through the band. The bench samples both edges of every band, which separates a held fault from a released one.

// File: rtl/prot_pkg.sv
package prot_pkg;
  typedef struct packed {
    logic ov;
    logic uv;
    logic ot;
    logic oc;
    logic cp;
    logic rg;
  } prot_flags_t;

  function automatic logic any_fault(input prot_flags_t f);
    return f.ov | f.uv | f.ot | f.oc | f.cp | f.rg;
  endfunction

  function automatic logic mute_fault(input prot_flags_t f);
    return f.ov | f.uv | f.ot;
  endfunction
endpackage

// File: rtl/prot_hyst_cmp.sv
module prot_hyst_cmp #(
  parameter int W     = 10,
  parameter int TRIP  = 300,
  parameter int REL   = 280,
  parameter bit ABOVE = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] val_i,
  output logic         flt_o
);
  localparam logic [W-1:0] TRIP_C = W'(TRIP);
  localparam logic [W-1:0] REL_C  = W'(REL);

  logic set_c, clr_c;

  generate
    if (ABOVE) begin : g_high
      assign set_c = val_i > TRIP_C;
      assign clr_c = val_i < REL_C;
    end else begin : g_low
      assign set_c = val_i < TRIP_C;
      assign clr_c = val_i > REL_C;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)        flt_o <= 1'b0;
    else if (set_c) flt_o <= 1'b1;
    else if (clr_c) flt_o <= 1'b0;
  end

  // Band behaviour for R2; the other instances carry it for R3 and R4.
  generate
    if (ABOVE) begin : g_chk_high
      assert_trip_R2: assert property (@(posedge clk) disable iff (rst)
        (val_i > TRIP_C) |=> flt_o);
      assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (flt_o && val_i >= REL_C) |=> flt_o);
      assert_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        (!flt_o && val_i <= TRIP_C) |=> !flt_o);
    end else begin : g_chk_low
      assert_trip_R3: assert property (@(posedge clk) disable iff (rst)
        (val_i < TRIP_C) |=> flt_o);
      assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (flt_o && val_i <= REL_C) |=> flt_o);
      assert_quiet_R3: assert property (@(posedge clk) disable iff (rst)
        (!flt_o && val_i >= TRIP_C) |=> !flt_o);
    end
  endgenerate
endmodule

// File: rtl/prot_oc_latch.sv
module prot_oc_latch #(
  parameter int NUM_CH     = 4,
  parameter int HOLD_TICKS = 600
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic [NUM_CH-1:0] oc_flag_i,
  output logic              latched_o
);
  localparam int CW = $clog2(HOLD_TICKS + 1);
  localparam logic [CW-1:0] HOLD_C = CW'(HOLD_TICKS);

  logic          any_oc;
  logic [CW-1:0] cnt_q;

  assign any_oc = |oc_flag_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      latched_o <= 1'b0;
      cnt_q     <= '0;
    end else if (any_oc) begin
      latched_o <= 1'b1;
      cnt_q     <= HOLD_C;
    end else if (latched_o && tick_i) begin
      if (cnt_q <= CW'(1)) begin
        latched_o <= 1'b0;
        cnt_q     <= '0;
      end else begin
        cnt_q <= cnt_q - CW'(1);
      end
    end
  end

  assert_set_R6: assert property (@(posedge clk) disable iff (rst)
    any_oc |=> latched_o);
  assert_rise_cause_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(latched_o) |-> $past(any_oc));
  assert_fall_cause_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(latched_o) |-> ($past(tick_i) && !$past(any_oc)));
  assert_restart_R7: assert property (@(posedge clk) disable iff (rst)
    any_oc |=> (cnt_q == HOLD_C));
  assert_idle_cnt_R1: assert property (@(posedge clk) disable iff (rst)
    !latched_o |-> (cnt_q == '0));
endmodule

// File: rtl/prot_fault_supervisor.sv
module prot_fault_supervisor #(
  parameter int VW         = 10,
  parameter int TW         = 8,
  parameter int NUM_CH     = 4,
  parameter int OV_TRIP    = 300,
  parameter int OV_REL     = 280,
  parameter int UV_TRIP    = 81,
  parameter int UV_REL     = 95,
  parameter int OT_TRIP    = 160,
  parameter int OT_REL     = 130,
  parameter int LD_TRIP    = 300,
  parameter int HOLD_TICKS = 600
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic [VW-1:0]     vsup_code_i,
  input  logic [TW-1:0]     temp_code_i,
  input  logic [NUM_CH-1:0] oc_flag_i,
  input  logic              cp_low_i,
  input  logic              reg_low_i,
  output logic              fault_o,
  output logic              mute_req_o,
  output logic              sleep_req_o,
  output logic              tristate_o
);
  import prot_pkg::*;

  localparam logic [VW-1:0] LD_C = VW'(LD_TRIP);

  prot_flags_t flags;
  logic        ld_q;

  prot_hyst_cmp #(.W(VW), .TRIP(OV_TRIP), .REL(OV_REL), .ABOVE(1'b1)) u_ov (
    .clk(clk), .rst(rst), .val_i(vsup_code_i), .flt_o(flags.ov));

  prot_hyst_cmp #(.W(VW), .TRIP(UV_TRIP), .REL(UV_REL), .ABOVE(1'b0)) u_uv (
    .clk(clk), .rst(rst), .val_i(vsup_code_i), .flt_o(flags.uv));

  prot_hyst_cmp #(.W(TW), .TRIP(OT_TRIP), .REL(OT_REL), .ABOVE(1'b1)) u_ot (
    .clk(clk), .rst(rst), .val_i(temp_code_i), .flt_o(flags.ot));

  prot_oc_latch #(.NUM_CH(NUM_CH), .HOLD_TICKS(HOLD_TICKS)) u_oc (
    .clk(clk), .rst(rst), .tick_i(tick_i), .oc_flag_i(oc_flag_i),
    .latched_o(flags.oc));

  // Stage one: the supply-rail flags and the surge compare.
  always_ff @(posedge clk) begin
    if (rst) begin
      flags.cp <= 1'b0;
      flags.rg <= 1'b0;
      ld_q     <= 1'b0;
    end else begin
      flags.cp <= cp_low_i;
      flags.rg <= reg_low_i;
      ld_q     <= vsup_code_i > LD_C;
    end
  end

  // Stage two: the registered action outputs.
  always_ff @(posedge clk) begin
    if (rst) begin
      fault_o     <= 1'b0;
      mute_req_o  <= 1'b0;
      sleep_req_o <= 1'b0;
      tristate_o  <= 1'b0;
    end else begin
      fault_o     <= any_fault(flags);
      mute_req_o  <= mute_fault(flags);
      sleep_req_o <= ld_q;
      tristate_o  <= any_fault(flags);
    end
  end

  assert_sleep_on_R5: assert property (@(posedge clk) disable iff (rst)
    (vsup_code_i > LD_C) |-> ##2 sleep_req_o);
  assert_sleep_off_R5: assert property (@(posedge clk) disable iff (rst)
    (vsup_code_i <= LD_C) |-> ##2 !sleep_req_o);
  assert_oc_action_R6: assert property (@(posedge clk) disable iff (rst)
    (|oc_flag_i) |-> ##2 (fault_o && tristate_o));
  assert_rail_action_R8: assert property (@(posedge clk) disable iff (rst)
    (cp_low_i || reg_low_i) |-> ##2 (fault_o && tristate_o));
  assert_mute_subset_R9: assert property (@(posedge clk) disable iff (rst)
    mute_req_o |-> fault_o);
endmodule

// File: tb/prot_fault_supervisor_tb_top.sv
module prot_fault_supervisor_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic [9:0] vsup = 10'd144;
  logic [7:0] temp = 8'd25;
  logic [3:0] oc = 4'd0;
  logic       cp = 1'b0;
  logic       rg = 1'b0;
  logic       fault, mute, sleep, tri_o;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  prot_fault_supervisor dut_i (
    .clk(clk), .rst(rst), .tick_i(tick), .vsup_code_i(vsup),
    .temp_code_i(temp), .oc_flag_i(oc), .cp_low_i(cp), .reg_low_i(rg),
    .fault_o(fault), .mute_req_o(mute), .sleep_req_o(sleep),
    .tristate_o(tri_o));

  task automatic chk(input string req, input logic [3:0] exp);
    logic [3:0] act;
    act = {fault, mute, sleep, tri_o};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: {fault,mute,sleep,tristate} actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
    end
  endtask

  task automatic t_reset();
    settle();
    chk("R1 reset", 4'b0000);
  endtask

  task automatic t_ov();
    @(negedge clk) vsup = 10'd300; settle(); chk("R2 at trip code", 4'b0000);
    @(negedge clk) vsup = 10'd301; settle(); chk("R2 above trip", 4'b1111);
    @(negedge clk) vsup = 10'd290; settle(); chk("R5 band, sleep gone", 4'b1101);
    @(negedge clk) vsup = 10'd280; settle(); chk("R2 at release code", 4'b1101);
    @(negedge clk) vsup = 10'd279; settle(); chk("R2 released", 4'b0000);
    @(negedge clk) vsup = 10'd144;
  endtask

  task automatic t_uv();
    @(negedge clk) vsup = 10'd81; settle(); chk("R3 at trip code", 4'b0000);
    @(negedge clk) vsup = 10'd80; settle(); chk("R3 below trip", 4'b1101);
    @(negedge clk) vsup = 10'd95; settle(); chk("R3 at release code", 4'b1101);
    @(negedge clk) vsup = 10'd96; settle(); chk("R3 released", 4'b0000);
    @(negedge clk) vsup = 10'd144;
  endtask

  task automatic t_ot();
    @(negedge clk) temp = 8'd160; settle(); chk("R4 at trip code", 4'b0000);
    @(negedge clk) temp = 8'd161; settle(); chk("R4 above trip", 4'b1101);
    @(negedge clk) temp = 8'd130; settle(); chk("R4 at release code", 4'b1101);
    @(negedge clk) temp = 8'd129; settle(); chk("R4 released", 4'b0000);
  endtask

  task automatic t_oc();
    @(negedge clk) oc = 4'b0100; settle(); chk("R6 set, no mute", 4'b1001);
    @(negedge clk) oc = 4'b0000; settle(); chk("R6 held without ticks", 4'b1001);
    ticks(599); settle(); chk("R6 held after 599 ticks", 4'b1001);
    ticks(1);   settle(); chk("R6 cleared on tick 600", 4'b0000);
  endtask

  task automatic t_restart();
    @(negedge clk) oc = 4'b0001;
    @(negedge clk) oc = 4'b0000;
    ticks(300);
    @(negedge clk) oc = 4'b1000;
    @(negedge clk) oc = 4'b0000;
    ticks(599); settle(); chk("R7 restarted count holds", 4'b1001);
    ticks(1);   settle(); chk("R7 clears 600 after restart", 4'b0000);
  endtask

  task automatic t_rails();
    @(negedge clk) cp = 1'b1; settle(); chk("R8 charge pump low", 4'b1001);
    @(negedge clk) cp = 1'b0; settle(); chk("R8 charge pump ok", 4'b0000);
    @(negedge clk) rg = 1'b1; settle(); chk("R8 regulator low", 4'b1001);
    @(negedge clk) rg = 1'b0; settle(); chk("R9 tristate follows fault", 4'b0000);
  endtask

  task automatic t_latency();
    @(negedge clk) cp = 1'b1;
    @(negedge clk) chk("R10 no change after one edge", 4'b0000);
    @(negedge clk) chk("R10 change after two edges", 4'b1001);
    cp = 1'b0;
    settle();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    t_reset();
    t_ov();
    t_uv();
    t_ot();
    t_oc();
    t_restart();
    t_rails();
    t_latency();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run hung, actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule